// File: doc/BRIEF.md
# Bus error event reporter

This block collects error events from the forwarding engine of a bus bridge and turns them into an active-low system-error output. It watches the delayed read that the bridge is currently retrying. It counts target retries and raises a retry-exhaustion event once the retry limit is reached without a completion. A master-timeout pulse and a parameterised set of further event pulses come in beside it.

Every event sets a sticky bit in a status register, whether or not the output is masked, so software can read why the error output fired. Software clears a bit by writing a one to it. Each event except master timeout has its own bit in a disable register. Master timeout is gated only by an enable bit in a control register. The error output goes low for one clock after each cycle that carries at least one event allowed through its gate.

Top module: `err_reporter`

## Requirements
- R1: After reset, each `retry_i` pulse without `done_i` is counted. The pulse that brings the count to `RETRY_LIMIT` (default 2^24) raises the retry-exhaustion event (status bit 0), and the count restarts from zero.
- R2: A cycle with `done_i` high clears the retry count. A `retry_i` in the same cycle as `done_i` is not counted.
- R3: A `mto_i` pulse is the master-timeout event (status bit 1). It drives the error output only while control bit 0 is set. Disable bit 1 cannot be set: it always reads 0 and has no effect.
- R4: Pulse `evt_i[i]` is an event that sets status bit 2+i.
- R5: A set disable bit k (k other than 1) keeps event k from driving the error output. Status bit k is still recorded.
- R6: Status bits are sticky. A write to address 0 clears each bit that has a 1 in the write data and leaves bits written 0 unchanged. An event in the same cycle as a clear of its bit leaves the bit set.
- R7: `serr_no` is low for exactly the cycle after each cycle in which any gated-through event occurs, and high otherwise. Events in back-to-back cycles keep it low for the same number of cycles.
- R8: Register map: address 0 is status, 1 is disable, 2 is control (bit 0 = master-timeout enable, other bits read 0), and 3 reads 0 and ignores writes. Reads are combinational from `reg_addr_i`.
- R9: Reset clears status, disable and control and drives `serr_no` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retry_i | input | 1 | Target retry received for the pending delayed read |
| done_i | input | 1 | Pending delayed read completed or discarded |
| mto_i | input | 1 | Master-timeout event pulse |
| evt_i | input | N_EXT | Further event pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | N_EXT+2 | Register write data |
| reg_rdata_o | output | N_EXT+2 | Register read data |
| serr_no | output | 1 | System-error output, active low |

## Verification
The race that matters is a software write-one-to-clear of a status bit landing in the same cycle as a new event on that bit. The bench drives an external event pulse together with the clearing write to address 0. It then reads the status back, expecting the bit still set, and a plain clear afterwards must empty it. A second same-cycle case puts `done_i` and `retry_i` together at a known count. The number of further retries needed before exhaustion shows whether that retry was dropped.

// File: rtl/err_rpt_pkg.sv
package err_rpt_pkg;
  localparam int EV_RETRY = 0;
  localparam int EV_MTO   = 1;
  localparam int EV_EXT0  = 2;

  typedef enum logic [1:0] {
    RA_STATUS  = 2'd0,
    RA_DISABLE = 2'd1,
    RA_CTRL    = 2'd2,
    RA_NONE    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/err_retry_cnt.sv
module err_retry_cnt #(
  parameter int LIMIT = 1 << 24,
  parameter int CW    = $clog2(LIMIT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          retry_i,
  input  logic          done_i,
  output logic          exh_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // completion wins over a retry in the same cycle
  assign exh_o = retry_i && !done_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (done_i)  cnt_q <= '0;
    else if (retry_i) cnt_q <= exh_o ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/err_status_regs.sv
module err_status_regs
  import err_rpt_pkg::*;
#(
  parameter int NUM_EV = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [NUM_EV-1:0] reg_wdata_i,
  output logic [NUM_EV-1:0] reg_rdata_o,
  output logic [NUM_EV-1:0] sts_o,
  output logic [NUM_EV-1:0] en_o
);
  localparam logic [NUM_EV-1:0] DIS_WMASK = ~(NUM_EV'(1) << EV_MTO);

  reg_addr_e            addr;
  logic [NUM_EV-1:0]    sts_q, dis_q, clr;
  logic                 mto_en_q;

  assign addr = reg_addr_e'(reg_addr_i);
  assign clr  = (reg_we_i && addr == RA_STATUS) ? reg_wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q    <= '0;
      dis_q    <= '0;
      mto_en_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr) | ev_i;  // new event beats clear
      if (reg_we_i && addr == RA_DISABLE) dis_q    <= reg_wdata_i & DIS_WMASK;
      if (reg_we_i && addr == RA_CTRL)    mto_en_q <= reg_wdata_i[0];
    end
  end

  for (genvar i = 0; i < NUM_EV; i++) begin : g_en
    if (i == EV_MTO) begin : g_mto
      assign en_o[i] = mto_en_q;
    end else begin : g_dis
      assign en_o[i] = !dis_q[i];
    end
  end

  always_comb begin
    unique case (addr)
      RA_STATUS:  reg_rdata_o = sts_q;
      RA_DISABLE: reg_rdata_o = dis_q;
      RA_CTRL:    reg_rdata_o = NUM_EV'(mto_en_q);
      default:    reg_rdata_o = '0;
    endcase
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/err_reporter.sv
module err_reporter
  import err_rpt_pkg::*;
#(
  parameter int  N_EXT       = 3,
  parameter int  RETRY_LIMIT = 1 << 24,
  localparam int NUM_EV      = N_EXT + 2,
  localparam int CNT_W       = $clog2(RETRY_LIMIT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retry_i,
  input  logic              done_i,
  input  logic              mto_i,
  input  logic [N_EXT-1:0]  evt_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [NUM_EV-1:0] reg_wdata_i,
  output logic [NUM_EV-1:0] reg_rdata_o,
  output logic              serr_no
);
  logic              exh;
  logic [CNT_W-1:0]  cnt_vec;
  logic [NUM_EV-1:0] ev_vec, en_vec, sts_vec;
  logic              serr_q;

  err_retry_cnt #(.LIMIT(RETRY_LIMIT), .CW(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .retry_i(retry_i),
    .done_i (done_i),
    .exh_o  (exh),
    .cnt_o  (cnt_vec)
  );

  assign ev_vec = {evt_i, mto_i, exh};

  err_status_regs #(.NUM_EV(NUM_EV)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev_vec),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .sts_o      (sts_vec),
    .en_o       (en_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) serr_q <= 1'b1;
    else         serr_q <= !(|(ev_vec & en_vec));
  end

  assign serr_no = serr_q;
endmodule

module err_reporter_chk
  import err_rpt_pkg::*;
#(
  parameter int NUM_EV      = 5,
  parameter int CNT_W       = 24,
  parameter int RETRY_LIMIT = 1 << 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [NUM_EV-1:0] ev_vec,
  input logic [NUM_EV-1:0] en_vec,
  input logic [NUM_EV-1:0] sts_vec,
  input logic [CNT_W-1:0]  cnt_vec,
  input logic              serr_no
);
  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_vec) < RETRY_LIMIT);

  assert_done_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> cnt_vec == '0);

  assert_mto_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_vec == (NUM_EV'(1) << EV_MTO)) && !en_vec[EV_MTO] |=> serr_no);

  assert_status_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_vec) |=> (sts_vec & $past(ev_vec)) == $past(ev_vec));

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == 2'd0) |=> (sts_vec & $past(sts_vec)) == $past(sts_vec));

  assert_serr_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ev_vec & en_vec)) |=> !serr_no);

  assert_serr_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(ev_vec & en_vec)) |=> serr_no);
endmodule

bind err_reporter err_reporter_chk #(
  .NUM_EV(NUM_EV), .CNT_W(CNT_W), .RETRY_LIMIT(RETRY_LIMIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .ev_vec(ev_vec), .en_vec(en_vec),
  .sts_vec(sts_vec), .cnt_vec(cnt_vec), .serr_no(serr_no)
);

// File: tb/sim_err_reporter.sv
module sim_err_reporter;
  localparam int CLK_PERIOD = 10;
  localparam int N_EXT      = 3;
  localparam int LIMIT      = 6;
  localparam int NUM_EV     = N_EXT + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              retry = 1'b0, done = 1'b0, mto = 1'b0, we = 1'b0;
  logic [N_EXT-1:0]  evt = '0;
  logic [1:0]        addr = '0;
  logic [NUM_EV-1:0] wdata = '0;
  logic [NUM_EV-1:0] rdata;
  logic              serr_n;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_reporter #(.N_EXT(N_EXT), .RETRY_LIMIT(LIMIT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .retry_i(retry), .done_i(done), .mto_i(mto),
    .evt_i(evt), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .serr_no(serr_n)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    addr = a; wdata = NUM_EV'(d); we = 1'b1;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic retries(int n);
    for (int i = 0; i < n; i++) begin
      retry = 1'b1; tick(); retry = 1'b0;
    end
  endtask

  task automatic t_reset();
    int v;
    chk("R9 serr", int'(serr_n), 1);
    rd(2'd0, v); chk("R9 status", v, 0);
    rd(2'd1, v); chk("R9 disable", v, 0);
    rd(2'd2, v); chk("R9 ctrl", v, 0);
  endtask

  task automatic t_retry();
    int v;
    retries(LIMIT - 1);
    chk("R1 no early serr", int'(serr_n), 1);
    rd(2'd0, v); chk("R1 no early status", v, 0);
    retries(1);
    chk("R1 serr on limit", int'(serr_n), 0);
    rd(2'd0, v); chk("R1 status bit0", v, 1);
    tick();
    chk("R7 one-cycle pulse", int'(serr_n), 1);
    wr(2'd0, 1);
    rd(2'd0, v); chk("R6 w1c clears", v, 0);
    retries(LIMIT - 1);
    rd(2'd0, v); chk("R1 count restarted", v, 0);
    done = 1'b1; tick(); done = 1'b0;
  endtask

  task automatic t_done();
    int v;
    retries(3);
    done = 1'b1; tick(); done = 1'b0;
    retries(LIMIT - 1);
    rd(2'd0, v); chk("R2 done clears count", v, 0);
    retry = 1'b1; done = 1'b1; tick(); retry = 1'b0; done = 1'b0;
    retries(LIMIT - 1);
    rd(2'd0, v); chk("R2 retry with done not counted", v, 0);
    retries(1);
    rd(2'd0, v); chk("R2 exhaustion after full limit", v, 1);
    wr(2'd0, 1);
  endtask

  task automatic t_mto();
    int v;
    mto = 1'b1; tick(); mto = 1'b0;
    chk("R3 mto gated off", int'(serr_n), 1);
    rd(2'd0, v); chk("R3 mto status", v, 2);
    wr(2'd0, 2);
    wr(2'd2, 1);
    rd(2'd2, v); chk("R8 ctrl read", v, 1);
    mto = 1'b1; tick(); mto = 1'b0;
    chk("R3 mto enabled", int'(serr_n), 0);
    wr(2'd1, 5'h1F);
    rd(2'd1, v); chk("R3 disable bit1 reads 0", v, 5'h1D);
    mto = 1'b1; tick(); mto = 1'b0;
    chk("R3 disable bit1 no effect", int'(serr_n), 0);
    evt = 3'b001; tick(); evt = '0;
    chk("R5 masked ext event", int'(serr_n), 1);
    rd(2'd0, v); chk("R5 masked still recorded", v, 5'h06);
    wr(2'd0, 5'h1F);
    wr(2'd1, 0);
    wr(2'd2, 0);
  endtask

  task automatic t_ext();
    int v;
    for (int i = 0; i < N_EXT; i++) begin
      evt = N_EXT'(1 << i); tick(); evt = '0;
      chk("R4 ext serr", int'(serr_n), 0);
      rd(2'd0, v); chk("R4 ext status bit", v, 1 << (i + 2));
      wr(2'd0, 5'h1F);
    end
    wr(2'd1, 1);
    retries(LIMIT);
    chk("R5 masked exhaustion", int'(serr_n), 1);
    rd(2'd0, v); chk("R5 exhaustion recorded", v, 1);
    wr(2'd0, 1);
    wr(2'd1, 0);
  endtask

  task automatic t_race();
    int v;
    evt = 3'b001; tick(); evt = '0;
    wr(2'd0, 0);
    rd(2'd0, v); chk("R6 write zero keeps", v, 4);
    addr = 2'd0; wdata = 5'h04; we = 1'b1; evt = 3'b001;
    tick();
    we = 1'b0; wdata = '0; evt = '0;
    rd(2'd0, v); chk("R6 event beats clear", v, 4);
    wr(2'd0, 4);
    rd(2'd0, v); chk("R6 clear after race", v, 0);
  endtask

  task automatic t_map_and_burst();
    int v;
    wr(2'd3, 5'h1F);
    rd(2'd3, v); chk("R8 addr3 reads 0", v, 0);
    rd(2'd1, v); chk("R8 addr3 write ignored", v, 0);
    rd(2'd2, v); chk("R8 addr3 ctrl untouched", v, 0);
    evt = 3'b110; tick();
    chk("R7 two events one pulse", int'(serr_n), 0);
    evt = 3'b100; tick(); evt = '0;
    chk("R7 back-to-back low", int'(serr_n), 0);
    tick();
    chk("R7 released", int'(serr_n), 1);
    rd(2'd0, v); chk("R4 both recorded", v, 5'h18);
    wr(2'd0, 5'h1F);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_retry();
    t_done();
    t_mto();
    t_ext();
    t_race();
    t_map_and_burst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule